// File: doc/BRIEF.md
# Drawing-Command Packet Framer

This block sits on the command path of a drawing engine. It takes a stream of 32-bit command words over a valid/ready handshake and groups them into whole command packets. It reads the opcode from the top byte of the first word of each packet. A length table keyed by that opcode gives the packet length for fixed-size commands. Two families of line-strip commands have no fixed length. Each of them runs until a terminator word whose masked value matches a fixed pattern.

A finished packet appears on a valid/ready output as a flat bank of words, with its opcode, its word count and flags that mark image-transfer commands. A strip longer than the word buffer leaves in buffer-sized segments, each flagged as a continuation. Environment-setting commands, opcodes 0xE0 to 0xE7, also copy their whole word into one of eight shadow registers, which stay visible on an output. The block does no drawing and touches no memory.

Top module: `pkt_framer`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and shadow register i (bits 32*i+31 down to 32*i of shadow_regs) holds (0xE0+i) shifted left by 24.
- R2: The packet opcode is bits 31:24 of its first word. out_opcode reports it, and word 0 of out_words is that first word.
- R3: Fixed packets are 1 + extra words long. The extra count is 2 for 0x02. For 0x20, 0x24, 0x28 and 0x2C, each a group of four, it is 3, 6, 4 and 8. For 0x30, 0x34, 0x38 and 0x3C it is 5, 8, 7 and 11. It is 2 for 0x40 to 0x47 and 3 for 0x50 to 0x57.
- R4: Every opcode not covered by R3, R5, R6 or R7 forms a one-word packet.
- R5: Opcodes 0x48 to 0x4F run until the first word at index 3 or later (index 0 is the opcode word) whose value ANDed with 0xF000F000 equals 0x50005000. That word is included in the packet.
- R6: Opcodes 0x58 to 0x5F test for the same terminator only at even indices of 4 or more. A matching word at an odd index, or at an index below 4, does not end the packet.
- R7: Opcodes 0xA0 to 0xDF form three-word packets with out_image = 1. out_image_read is 1 only for 0xC0 to 0xDF.
- R8: A first word with opcode 0xE0 to 0xE7 stores the whole word in shadow register (opcode & 7) and is framed as a one-word packet.
- R9: A packet whose words have not all arrived is not presented: out_valid stays 0.
- R10: A strip that reaches DEPTH words without a terminator is presented as a DEPTH-word segment with out_cont = 1. Later segments carry the same opcode, and only the final segment has out_cont = 0.
- R11: pkt_done pulses for one cycle in the cycle a non-continuation packet first appears. poly_end pulses with it only when a terminator ended the packet.
- R12: While out_valid is 1, in_ready is 0, and the presented packet holds steady until out_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Command word |
| out_valid | output | 1 | Packet or segment presented |
| out_ready | input | 1 | Consumer takes the packet |
| out_words | output | 32*DEPTH | Packet words, word i at bits 32*i+31 down to 32*i |
| out_count | output | $clog2(DEPTH+1) | Number of valid words |
| out_opcode | output | 8 | Packet opcode |
| out_cont | output | 1 | Segment of a strip that continues |
| out_image | output | 1 | Image-transfer command |
| out_image_read | output | 1 | Image transfer is a read |
| pkt_done | output | 1 | Pulse on each finished packet |
| poly_end | output | 1 | Pulse on each terminator-ended strip |
| shadow_regs | output | 256 | Eight environment shadow registers |

## Verification
Every packet result comes from a register loaded on the edge that accepts the packet's last word. The bench drives inputs on falling edges and reads out_valid, out_count, out_opcode, the flags and pkt_done on the falling edge that follows the accepting edge. It checks out_valid again one word before the last, to confirm that nothing appeared early. A shadow register changes on the same edge that accepts its word and is read half a cycle later. Each pulse is also read one cycle later with out_ready held low, both to confirm that it has dropped and to confirm that the held packet has not moved.

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int DEPTH = 16,
  parameter int POSW  = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [31:0]           in_word,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [32*DEPTH-1:0]   out_words,
  output logic [$clog2(DEPTH+1)-1:0] out_count,
  output logic [7:0]            out_opcode,
  output logic                  out_cont,
  output logic                  out_image,
  output logic                  out_image_read,
  output logic                  pkt_done,
  output logic                  poly_end,
  output logic [255:0]          shadow_regs
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  function automatic logic [3:0] extra_words(input logic [7:0] op);
    logic [3:0] r;
    casez (op)
      8'h02:        r = 4'd2;
      8'b001?????: begin
        case (op[4:2])
          3'd0: r = 4'd3;  3'd1: r = 4'd6;  3'd2: r = 4'd4;  3'd3: r = 4'd8;
          3'd4: r = 4'd5;  3'd5: r = 4'd8;  3'd6: r = 4'd7;  default: r = 4'd11;
        endcase
      end
      8'b01000???:  r = 4'd2;
      8'b01010???:  r = 4'd3;
      8'b101?????,
      8'b110?????:  r = 4'd2;
      default:      r = 4'd0;
    endcase
    return r;
  endfunction

  logic [31:0]     buf_q [DEPTH];
  logic [31:0]     shadow_q [8];
  logic [IW-1:0]   idx_q;
  logic [POSW-1:0] pos_q;
  logic [7:0]      op_q;
  logic [CW-1:0]   cnt_q;
  logic            valid_q, cont_q, done_q, pend_q;

  wire             accept   = in_valid && !valid_q;
  wire             first    = (pos_q == '0);
  wire [7:0]       cur_op   = first ? in_word[31:24] : op_q;
  wire             is_flat  = (cur_op[7:3] == 5'b01001);
  wire             is_shad  = (cur_op[7:3] == 5'b01011);
  wire             term     = ((in_word & 32'hF000F000) == 32'h50005000);
  wire             term_hit = term && ((is_flat && pos_q >= POSW'(3)) ||
                                       (is_shad && pos_q >= POSW'(4) && !pos_q[0]));
  wire             fixed_done = !is_flat && !is_shad &&
                                (pos_q == POSW'(extra_words(cur_op)));
  wire             done     = term_hit || fixed_done;
  wire             seg_full = !done && (idx_q == IW'(DEPTH-1));
  wire [POSW-1:0]  pos_nx   = (&pos_q) ? pos_q - 1'b1 : pos_q + 1'b1;

  assign in_ready       = !valid_q;
  assign out_valid      = valid_q;
  assign out_count      = cnt_q;
  assign out_opcode     = op_q;
  assign out_cont       = cont_q;
  assign out_image      = (op_q[7:5] == 3'b101) || (op_q[7:5] == 3'b110);
  assign out_image_read = (op_q[7:5] == 3'b110);
  assign pkt_done       = done_q;
  assign poly_end       = pend_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_words
    assign out_words[32*g +: 32] = buf_q[g];
  end
  for (genvar s = 0; s < 8; s++) begin : g_shadow
    assign shadow_regs[32*s +: 32] = shadow_q[s];
  end

  always_ff @(posedge clk) begin
    if (accept) buf_q[idx_q] <= in_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) shadow_q[i] <= {8'hE0 + 8'(i), 24'h0};
    end else if (accept && first && in_word[31:27] == 5'b11100) begin
      shadow_q[in_word[26:24]] <= in_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      pos_q   <= '0;
      op_q    <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      cont_q  <= 1'b0;
      done_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pend_q <= 1'b0;
      if (valid_q && out_ready) valid_q <= 1'b0;
      if (accept) begin
        if (first) op_q <= in_word[31:24];
        if (done) begin
          valid_q <= 1'b1;
          cont_q  <= 1'b0;
          cnt_q   <= CW'(idx_q) + 1'b1;
          idx_q   <= '0;
          pos_q   <= '0;
          done_q  <= 1'b1;
          pend_q  <= term_hit;
        end else if (seg_full) begin
          valid_q <= 1'b1;
          cont_q  <= 1'b1;
          cnt_q   <= CW'(DEPTH);
          idx_q   <= '0;
          pos_q   <= pos_nx;
        end else begin
          idx_q   <= idx_q + 1'b1;
          pos_q   <= pos_nx;
        end
      end
    end
  end

  assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !out_ready |=> valid_q && $stable(cnt_q) && $stable(op_q) && $stable(cont_q));

  assert_done_with_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> out_valid && !out_cont);

  assert_done_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);

  assert_poly_end_strip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    poly_end |-> pkt_done && (op_q[7:3] == 5'b01001 || op_q[7:3] == 5'b01011));

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_count != '0 && out_count <= CW'(DEPTH));

  assert_segment_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cont |-> out_count == CW'(DEPTH));
endmodule

// File: tb/sim_pkt_framer.sv
module sim_pkt_framer;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] in_word = '0;
  logic in_ready, out_valid, out_cont, out_image, out_image_read, pkt_done, poly_end;
  logic [32*DEPTH-1:0] out_words;
  logic [CW-1:0] out_count;
  logic [7:0] out_opcode;
  logic [255:0] shadow_regs;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  pkt_framer #(.DEPTH(DEPTH), .POSW(12)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_words(out_words), .out_count(out_count),
    .out_opcode(out_opcode), .out_cont(out_cont), .out_image(out_image),
    .out_image_read(out_image_read), .pkt_done(pkt_done), .poly_end(poly_end),
    .shadow_regs(shadow_regs));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    in_valid = 1'b1;
    in_word  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  function automatic int exp_len(input int op);
    int grp_tab [8] = '{3, 6, 4, 8, 5, 8, 7, 11};
    if (op == 2) return 3;
    if (op >= 'h20 && op <= 'h3F) return 1 + grp_tab[(op - 'h20) / 4];
    if (op >= 'h40 && op <= 'h47) return 3;
    if (op >= 'h50 && op <= 'h57) return 4;
    if (op >= 'hA0 && op <= 'hDF) return 3;
    return 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid", {31'b0, out_valid}, 0);
    chk("R1 in_ready", {31'b0, in_ready}, 1);
    for (int i = 0; i < 8; i++)
      chk("R1 shadow", shadow_regs[32*i +: 32], (32'hE0 + i) << 24);

    for (int op = 0; op < 256; op++) begin
      int n;
      if ((op >= 'h48 && op <= 'h4F) || (op >= 'h58 && op <= 'h5F)) continue;
      n = exp_len(op);
      push({op[7:0], 16'h0000, op[7:0]});
      for (int k = 1; k < n; k++) begin
        if (k == n - 1) chk("R9 early", {31'b0, out_valid}, 0);
        push(32'h0000_0000);
      end
      chk("R3 R4 valid", {31'b0, out_valid}, 1);
      chk("R3 R4 count", 32'(out_count), n);
      chk("R2 opcode", 32'(out_opcode), op);
      chk("R2 word0", out_words[31:0], {op[7:0], 16'h0000, op[7:0]});
      chk("R7 image", {31'b0, out_image}, (op >= 'hA0 && op <= 'hDF) ? 1 : 0);
      chk("R7 read", {31'b0, out_image_read}, (op >= 'hC0 && op <= 'hDF) ? 1 : 0);
      chk("R11 done", {30'b0, pkt_done, poly_end}, 2);
      if (op >= 'hE0 && op <= 'hE7)
        chk("R8 shadow", shadow_regs[32*(op-'hE0) +: 32], {op[7:0], 16'h0000, op[7:0]});
      pop();
    end

    push(32'h2C00_0001);
    for (int k = 1; k < 9; k++) push(32'h1000_0000 + k);
    @(negedge clk);
    chk("R11 pulse drop", {31'b0, pkt_done}, 0);
    chk("R12 in_ready", {31'b0, in_ready}, 0);
    chk("R12 held count", 32'(out_count), 9);
    chk("R12 held word", out_words[32*8 +: 32], 32'h1000_0008);
    pop();

    push(32'h4800_0000);
    push(32'h1111_1111);
    push(32'h5555_5555);
    push(32'h0000_0003);
    push(32'h0000_0004);
    chk("R5 not yet", {31'b0, out_valid}, 0);
    push(32'h5123_5456);
    chk("R5 count", 32'(out_count), 6);
    chk("R5 pulses", {30'b0, pkt_done, poly_end}, 3);
    pop();

    push(32'h5A00_0000);
    push(32'h0000_0001);
    push(32'h0000_0002);
    push(32'h5A00_5A00);
    push(32'h0000_0004);
    push(32'h5000_5000);
    chk("R6 odd ignored", {31'b0, out_valid}, 0);
    push(32'h5FFF_5FFF);
    chk("R6 count", 32'(out_count), 7);
    chk("R6 opcode", 32'(out_opcode), 32'h5A);
    chk("R6 pulses", {30'b0, pkt_done, poly_end}, 3);
    pop();

    push(32'h4A00_0000);
    for (int k = 1; k < DEPTH; k++) push(32'h0000_0100 + k);
    chk("R10 seg valid", {31'b0, out_valid}, 1);
    chk("R10 seg count", 32'(out_count), DEPTH);
    chk("R10 seg cont", {31'b0, out_cont}, 1);
    chk("R10 seg no done", {31'b0, pkt_done}, 0);
    pop();
    for (int k = DEPTH; k < 20; k++) push(32'h0000_0100 + k);
    push(32'h5000_5000);
    chk("R10 tail count", 32'(out_count), 21 - DEPTH);
    chk("R10 tail cont", {31'b0, out_cont}, 0);
    chk("R10 tail opcode", 32'(out_opcode), 32'h4A);
    chk("R10 tail pulses", {30'b0, pkt_done, poly_end}, 3);
    pop();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule